// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Claim and Complete

This block gathers level-sensitive interrupt requests from up to 31 external sources and forwards them to two target contexts. Every source has a 3-bit priority. Every context has its own enable bitmap, its own priority threshold and one registered interrupt output line. A context raises its line when at least one source is pending, enabled for that context and ranked strictly above that context's threshold.

Software services a context through a claim register. Reading it returns the identifier of the best eligible source and takes that source out of the pending set. The source's gateway then blocks new requests from that source. Writing the same identifier back to the claim register completes the interrupt. After that, a request that is still held high latches as pending again. All access goes through one 32-bit word-addressed read/write port. Read data appears one clock after the request.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, every priority, enable and threshold register reads 0, both claim registers read 0 and both `irq_o` bits are 0.
- R2: The priority of source n (1..31) is at word address n and holds bits [2:0] of the written data. Other data bits read back as 0. Word address 0 (source 0) reads 0 and ignores writes.
- R3: The enable word of context c is at word address 0x800 + c*0x20. Bit n enables source n for that context. Bit 0 always reads 0.
- R4: The threshold of context c (3 bits, data bits [2:0]) is at word address 0x80000 + c*0x400, and its claim/complete register is at that address + 1. Each context's claim and output depend only on its own enable word and threshold.
- R5: A pending, enabled source is eligible for a context only when its priority is strictly greater than that context's threshold. A source with priority 0 is never eligible.
- R6: A claim read returns the identifier of the eligible source with the highest priority. Equal priorities resolve to the lowest identifier. With no eligible source the read returns 0.
- R7: `irq_src[n]` high latches source n as pending. A claim read returning n clears that pending bit and blocks source n until a completion write of n to a claim register. After that completion, a still-high `irq_src[n]` makes the source pending again.
- R8: A completion write whose value is 0, greater than 31, or the identifier of a source that is not currently claimed, changes nothing.
- R9: Reads of unmapped word addresses return 0, and writes to them leave every register unchanged.
- R10: `irq_o[c]` is registered. It follows eligibility one clock later and rises with no software action when a threshold is lowered below a pending enabled source's priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 31 | Level request of sources 31..1, bit n is source n |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 2 | Interrupt line of each context |

## Verification
The gateway checks assume that a claim reaches a source only while it is pending. That holds as long as the selection logic picks only pending sources, so the bench never forces a claim from outside. The completion checks take the write data as a full 32-bit value. The bench therefore sends out-of-range identifiers and identifiers of sources that are not claimed, and never writes completions to other addresses. The bench drives at most one register access per cycle and holds the source levels steady across each claim sequence, so that its arithmetic model of the claim order stays exact.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;

  // word address helpers of the register map
  function automatic int enable_word(int c);
    return 'h800 + c * 'h20;
  endfunction

  function automatic int thresh_word(int c);
    return 'h80000 + c * 'h400;
  endfunction

  function automatic int claim_word(int c);
    return thresh_word(c) + 1;
  endfunction

  // strict comparison used both for the threshold gate and for ranking
  function automatic logic prio_above(prio_t p, prio_t floor_p);
    return p > floor_p;
  endfunction
endpackage

// File: rtl/lic_gateway.sv
module lic_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic claim,
  input  logic complete,
  output logic pending,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      busy    <= 1'b0;
    end else if (claim) begin
      pending <= 1'b0;
      busy    <= 1'b1;
    end else if (complete && busy) begin
      busy <= 1'b0;
    end else if (lvl && !busy) begin
      pending <= 1'b1;
    end
  end

  assert_claim_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> pending);
  assert_claim_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> (busy && !pending));
  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !complete) |=> !pending);
  assert_pending_busy_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && busy));
endmodule

// File: rtl/lic_select.sv
module lic_select import lic_pkg::*; #(
  parameter int NSRC = 31,
  parameter int ID_W = 5
) (
  input  logic [NSRC:1]           pend,
  input  logic [NSRC:1]           en,
  input  logic [NSRC*PRIO_W-1:0]  prio_flat,
  input  prio_t                   thr,
  output logic [ID_W-1:0]         best_id
);
  prio_t best_p;
  prio_t cand_p;

  // ascending scan with strict compare: ties keep the lowest id
  always_comb begin
    best_id = '0;
    best_p  = thr;
    cand_p  = '0;
    for (int n = 1; n <= NSRC; n++) begin
      cand_p = prio_flat[(n-1)*PRIO_W +: PRIO_W];
      if (pend[n] && en[n] && prio_above(cand_p, best_p)) begin
        best_id = ID_W'(n);
        best_p  = cand_p;
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl import lic_pkg::*; #(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     irq_src,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCTX-1:0]   irq_o
);
  localparam int ID_W   = $clog2(NSRC + 1);
  localparam int STATEW = NSRC*PRIO_W + NCTX*NSRC + NCTX*PRIO_W;

  prio_t             prio_q [1:NSRC];
  logic [NSRC:1]     en_q   [NCTX];
  prio_t             thr_q  [NCTX];
  logic [NSRC*PRIO_W-1:0] prio_flat;

  logic [NSRC:1]     pend_vec, busy_vec, claim_vec, done_vec;
  logic [ID_W-1:0]   best_id [NCTX];

  logic              wr_en, rd_en, hit_prio, unmapped;
  logic [NCTX-1:0]   hit_en, hit_thr, hit_clm;
  logic [DATA_W-1:0] rd_mux;
  logic [STATEW-1:0] state_flat;

  // ---------------- address decode ----------------
  always_comb begin
    wr_en    = req_valid && req_write;
    rd_en    = req_valid && !req_write;
    hit_prio = (req_addr != '0) && (req_addr <= ADDR_W'(NSRC));
    for (int c = 0; c < NCTX; c++) begin
      hit_en[c]  = req_addr == ADDR_W'(enable_word(c));
      hit_thr[c] = req_addr == ADDR_W'(thresh_word(c));
      hit_clm[c] = req_addr == ADDR_W'(claim_word(c));
    end
    unmapped = !(hit_prio || (|hit_en) || (|hit_thr) || (|hit_clm));
  end

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 1; n <= NSRC; n++) prio_q[n] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (wr_en) begin
      if (hit_prio) prio_q[req_addr[ID_W-1:0]] <= req_wdata[PRIO_W-1:0];
      for (int c = 0; c < NCTX; c++) begin
        if (hit_en[c])  en_q[c]  <= req_wdata[NSRC:1];
        if (hit_thr[c]) thr_q[c] <= req_wdata[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    for (int n = 1; n <= NSRC; n++) prio_flat[(n-1)*PRIO_W +: PRIO_W] = prio_q[n];
  end

  // ---------------- gateways ----------------
  for (genvar n = 1; n <= NSRC; n++) begin : g_src
    lic_gateway u_gw (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (irq_src[n]),
      .claim    (claim_vec[n]),
      .complete (done_vec[n]),
      .pending  (pend_vec[n]),
      .busy     (busy_vec[n])
    );
  end

  // ---------------- per-context selection ----------------
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    lic_select #(.NSRC(NSRC), .ID_W(ID_W)) u_sel (
      .pend      (pend_vec),
      .en        (en_q[c]),
      .prio_flat (prio_flat),
      .thr       (thr_q[c]),
      .best_id   (best_id[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) irq_o[c] <= 1'b0;
      else        irq_o[c] <= best_id[c] != '0;
    end

    assert_claim_over_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit_clm[c] && best_id[c] != '0) |->
        (prio_q[best_id[c]] > thr_q[c]));
  end

  // ---------------- claim and completion events ----------------
  always_comb begin
    claim_vec = '0;
    done_vec  = '0;
    for (int c = 0; c < NCTX; c++) begin
      for (int n = 1; n <= NSRC; n++) begin
        if (rd_en && hit_clm[c] && best_id[c] == ID_W'(n)) claim_vec[n] = 1'b1;
        if (wr_en && hit_clm[c] && req_wdata == DATA_W'(n)) done_vec[n] = 1'b1;
      end
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    rd_mux = '0;
    if (hit_prio) rd_mux = DATA_W'(prio_q[req_addr[ID_W-1:0]]);
    for (int c = 0; c < NCTX; c++) begin
      if (hit_en[c])  rd_mux = DATA_W'({en_q[c], 1'b0});
      if (hit_thr[c]) rd_mux = DATA_W'(thr_q[c]);
      if (hit_clm[c]) rd_mux = DATA_W'(best_id[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // ---------------- observation of configuration state ----------------
  always_comb begin
    state_flat = '0;
    state_flat[NSRC*PRIO_W-1:0] = prio_flat;
    for (int c = 0; c < NCTX; c++) begin
      state_flat[NSRC*PRIO_W + c*NSRC +: NSRC] = en_q[c];
      state_flat[NSRC*PRIO_W + NCTX*NSRC + c*PRIO_W +: PRIO_W] = thr_q[c];
    end
  end

  assert_bad_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|hit_clm) && (req_wdata == '0 || req_wdata > DATA_W'(NSRC)))
      |=> $stable(busy_vec));
  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped) |=> $stable(state_flat));
  assert_config_write_keeps_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(|hit_clm)) |=> ($past(busy_vec) == busy_vec));
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  localparam int EN0 = 'h800, EN1 = 'h820, TH0 = 'h80000, TH1 = 'h80400;
  localparam int CL0 = 'h80001, CL1 = 'h80401;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:1] irq_src = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 20'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 20'(a);
    @(negedge clk);
    d = rd_data;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; irq_src = '0; req_valid = 0;
    idle(3);
    rst_n = 1;
    idle(1);
  endtask

  function automatic int pr(int n);
    return (n * 5 + 3) % 8;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit taken [32];
    int exp, bp;

    // ---- R1 reset state
    do_reset();
    chk("R1 irq_o after reset", irq_o, 0);
    for (int n = 1; n <= 31; n++) begin rd(n, d); chk("R1 priority reset", d, 0); end
    rd(EN0, d); chk("R1 enable0 reset", d, 0);
    rd(EN1, d); chk("R1 enable1 reset", d, 0);
    rd(TH0, d); chk("R1 threshold0 reset", d, 0);
    rd(TH1, d); chk("R1 threshold1 reset", d, 0);
    rd(CL0, d); chk("R1 claim0 reset", d, 0);
    rd(CL1, d); chk("R1 claim1 reset", d, 0);

    // ---- R2 priority sweep
    for (int n = 1; n <= 31; n++) wr(n, 32'hFFFF_FFF8 | 32'((n * 3) & 7));
    for (int n = 1; n <= 31; n++) begin rd(n, d); chk("R2 priority readback", d, (n * 3) & 7); end
    wr(0, 7); rd(0, d); chk("R2 source0 priority", d, 0);
    for (int n = 1; n <= 31; n++) wr(n, 0);

    // ---- R3 enable words
    wr(EN0, 32'hFFFF_FFFF); rd(EN0, d); chk("R3 enable0 bit0 zero", d, 32'hFFFF_FFFE);
    wr(EN1, 32'h0000_AAAB); rd(EN1, d); chk("R3 enable1 readback", d, 32'h0000_AAAA);
    wr(EN0, 0); wr(EN1, 0);

    // ---- R4 thresholds, R9 unmapped
    wr(TH0, 32'hF5); rd(TH0, d); chk("R4 threshold0 readback", d, 5);
    wr(TH1, 3);      rd(TH1, d); chk("R4 threshold1 readback", d, 3);
    wr('h20, 7); wr('h801, 32'hFFFF); wr('h80002, 7); wr('h80800, 7); wr('h2000, 7);
    rd('h20, d);    chk("R9 unmapped read 0x20", d, 0);
    rd('h801, d);   chk("R9 unmapped read 0x801", d, 0);
    rd('h80002, d); chk("R9 unmapped read 0x80002", d, 0);
    rd('h80800, d); chk("R9 unmapped read 0x80800", d, 0);
    rd(TH0, d); chk("R9 threshold0 untouched", d, 5);
    rd(TH1, d); chk("R9 threshold1 untouched", d, 3);
    rd(EN0, d); chk("R9 enable0 untouched", d, 0);
    rd(1, d);   chk("R9 priority1 untouched", d, 0);

    // ---- R5 / R10 priority-threshold sweep on source 5
    do_reset();
    irq_src[5] = 1;
    wr(EN0, 32'h20);
    for (int p = 0; p < 8; p++) begin
      for (int t = 7; t >= 0; t--) begin
        wr(5, p); wr(TH0, t);
        idle(2);
        chk("R5 R10 irq_o[0] versus threshold", irq_o[0], (p > t) ? 1 : 0);
        chk("R4 irq_o[1] stays low", irq_o[1], 0);
      end
    end
    // threshold lowered while pending: output rises without other action
    wr(5, 4); wr(TH0, 6); idle(2);
    chk("R10 masked by threshold", irq_o[0], 0);
    wr(TH0, 3); idle(1);
    chk("R10 rises after threshold lowered", irq_o[0], 1);

    // ---- R6 arbitration, two rounds
    do_reset();
    for (int n = 1; n <= 31; n++) wr(n, pr(n));
    wr(EN0, 32'hFFFF_FFFE);
    irq_src = '1;
    idle(3);
    chk("R6 irq_o[0] with pending sources", irq_o[0], 1);
    for (int n = 0; n < 32; n++) taken[n] = 0;
    for (int k = 0; k < 33; k++) begin
      exp = 0; bp = 0;
      for (int n = 1; n <= 31; n++) if (!taken[n] && pr(n) > bp) begin exp = n; bp = pr(n); end
      rd(CL0, d);
      chk("R6 claim order threshold 0", d, exp);
      if (exp == 0) break;
      taken[exp] = 1;
    end
    idle(2);
    chk("R7 irq_o[0] low with all claimed", irq_o[0], 0);
    for (int n = 1; n <= 31; n++) if (taken[n]) wr(CL0, n);
    idle(3);
    wr(TH0, 4);
    for (int n = 0; n < 32; n++) taken[n] = 0;
    for (int k = 0; k < 33; k++) begin
      exp = 0; bp = 4;
      for (int n = 1; n <= 31; n++) if (!taken[n] && pr(n) > bp) begin exp = n; bp = pr(n); end
      rd(CL0, d);
      chk("R5 R6 claim order threshold 4", d, exp);
      if (exp == 0) break;
      taken[exp] = 1;
    end

    // ---- R7 / R8 gateway and completion
    do_reset();
    wr(3, 4); wr(EN0, 32'h8);
    irq_src[3] = 1;
    idle(3);
    rd(CL0, d); chk("R7 claim source 3", d, 3);
    idle(2);
    chk("R7 irq_o[0] low while in flight", irq_o[0], 0);
    wr(CL0, 7); wr(CL0, 0); wr(CL0, 35); wr(CL0, 32'h0000_0103);
    idle(3);
    rd(CL0, d); chk("R8 bad completions ignored", d, 0);
    chk("R8 irq_o[0] still low", irq_o[0], 0);
    wr(CL0, 3);
    idle(3);
    chk("R7 re-pend after completion", irq_o[0], 1);
    rd(CL0, d); chk("R7 claim again after completion", d, 3);
    irq_src[3] = 0;
    wr(CL0, 3);
    idle(3);
    rd(CL0, d); chk("R7 no re-pend with input low", d, 0);
    chk("R7 irq_o[0] low with input low", irq_o[0], 0);

    // ---- R4 context independence
    do_reset();
    wr(10, 6); wr(EN1, 32'h400);
    irq_src[10] = 1;
    idle(3);
    chk("R4 only context 1 raised", irq_o, 2'b10);
    rd(CL0, d); chk("R4 claim0 sees nothing", d, 0);
    rd(CL1, d); chk("R4 claim1 returns 10", d, 10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule